// File: doc/BRIEF.md
# Binary Overlap Search Engine

This block looks for the best alignment between two binary images of W columns by H rows. Image A is on the left and image B is on the right. The engine tries every candidate placement of B against A. A placement is given by a column overlap c, where the last c columns of A lie over the first c columns of B, and by a signed vertical shift s. At each placement the engine compares every overlapping pixel pair, counts the pairs that differ, and scores the placement by the fraction of pairs that differ. It keeps only the best placement seen so far, so no per-placement score is stored.

A search begins with a start pulse. The engine then fetches one pixel pair per cycle through two read ports. Each port drives a column and row address and receives the addressed pixel combinationally in the same cycle. When the sweep ends, done rises. The winning column overlap, vertical shift and compared-pixel count then stay on the result outputs until the next search begins. A mode input chosen at start selects either a horizontal-only sweep or a full two-dimensional sweep.

Top module: `ovl_search_top`

## Requirements
- R1: After reset, busy_o and done_o are low, and best_cols_o, best_shift_o and best_count_o are zero.
- R2: A start_i pulse seen while busy_o is low begins a search. In the next cycle busy_o is high and done_o is low. A start_i pulse while busy_o is high is ignored and changes neither the run length nor the result.
- R3: The engine checks exactly one pixel pair per cycle. busy_o stays high for exactly P cycles, where P is the sum of c*(H-|s|) over all placements swept. done_o rises in the cycle after the last of these.
- R4: At placement (c, s), pixel A(x, y) is paired with pixel B(x-(W-c), y-s) for every x from W-c to W-1 and every row y where both rows exist. All addresses driven while busy are inside the images, with the column index before the row index.
- R5: The score of a placement is its mismatch count divided by its pair count, where a pair mismatches when its two pixels differ. The placement with the lowest score wins.
- R6: When two placements have equal scores, the one with more compared pixels wins.
- R7: When two placements have equal scores and equal pair counts, the one visited first wins. The sweep order is c ascending from 1 to W, and within each c, s ascending.
- R8: With mode_2d_i low at start, only s = 0 is swept, and best_shift_o is 0.
- R9: With mode_2d_i high at start, s runs from -(H-1) to +(H-1) for every c, giving 2H-1 shifts for each column overlap.
- R10: While done_o is high, the three result outputs hold their values. best_count_o equals best_cols_o*(H-|best_shift_o|). The results hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search |
| mode_2d_i | input | 1 | 1: sweep vertical shifts too; 0: horizontal only |
| a_x_o | output | $clog2(W) | Column address into image A |
| a_y_o | output | $clog2(H) | Row address into image A |
| a_pix_i | input | 1 | Pixel of A at the driven address |
| b_x_o | output | $clog2(W) | Column address into image B |
| b_y_o | output | $clog2(H) | Row address into image B |
| b_pix_i | input | 1 | Pixel of B at the driven address |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result valid |
| best_cols_o | output | $clog2(W+1) | Winning column overlap c |
| best_shift_o | output | $clog2(H)+1 | Winning vertical shift s, two's complement |
| best_count_o | output | $clog2(W*H+1) | Pixel pairs compared at the winning placement |

## Verification
The bench tests two flat cases. Identical blank images make every score zero, and complementary flat images make every score one. In both cases only the larger-count tie-break can pick the full overlap. Row-striped images that are out of phase match only at odd shifts, and shifts +1 and -1 have equal counts, which isolates the first-visited rule. Planted overlaps inside random images check the pairing geometry and the minimum search in both modes. Fully random images check the scoring itself. In random images a one-pixel placement that happens to match often beats larger ones, so these cases also check the normalisation by pair count rather than by raw mismatch count.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } ovl_state_t;
endpackage

// File: rtl/ovl_offset_walker.sv
// Walks every placement and, inside each, every overlapping pixel pair.
module ovl_offset_walker #(
    parameter int W = 8,
    parameter int H = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          init_i,
    input  logic                          step_i,
    input  logic                          mode_2d_i,
    output logic [$clog2(W)-1:0]          a_x_o,
    output logic [$clog2(H)-1:0]          a_y_o,
    output logic [$clog2(W)-1:0]          b_x_o,
    output logic [$clog2(H)-1:0]          b_y_o,
    output logic [$clog2(W+1)-1:0]        cols_o,
    output logic signed [$clog2(H):0]     shift_o,
    output logic [$clog2(W*H+1)-1:0]      count_o,
    output logic                          last_pix_o,
    output logic                          last_off_o
);
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);
    localparam int CW = $clog2(W+1);
    localparam int SW = $clog2(H) + 1;
    localparam int RW = $clog2(H+1);
    localparam int NW = $clog2(W*H+1);
    localparam logic [CW-1:0]        WC   = CW'(W);
    localparam logic signed [SW-1:0] SMAX = SW'(H-1);

    typedef struct packed {
        logic [CW-1:0]        cols;
        logic signed [SW-1:0] shift;
        logic [YW-1:0]        row;
        logic [XW-1:0]        col;
    } walk_t;

    walk_t q, d;
    logic [SW-1:0]        mag;
    logic [RW-1:0]        rows;
    logic signed [SW-1:0] smin, smax;
    logic [CW-1:0]        xoff;
    logic [YW-1:0]        ya0, yb0;
    logic                 last_col, last_row;

    always_comb begin
        mag      = q.shift[SW-1] ? SW'(-q.shift) : SW'(q.shift);
        rows     = RW'(H) - RW'(mag);
        smax     = mode_2d_i ? SMAX : '0;
        smin     = mode_2d_i ? -SMAX : '0;
        xoff     = WC - q.cols;
        ya0      = (q.shift > 0) ? mag[YW-1:0] : '0;
        yb0      = (q.shift < 0) ? mag[YW-1:0] : '0;
        last_col = (CW'(q.col) == (q.cols - 1'b1));
        last_row = (RW'(q.row) == (rows - 1'b1));

        a_x_o      = xoff[XW-1:0] + q.col;
        b_x_o      = q.col;
        a_y_o      = ya0 + q.row;
        b_y_o      = yb0 + q.row;
        cols_o     = q.cols;
        shift_o    = q.shift;
        count_o    = NW'(q.cols) * NW'(rows);
        last_pix_o = last_col && last_row;
        last_off_o = (q.cols == WC) && (q.shift == smax);

        d = q;
        if (init_i) begin
            d.cols  = CW'(1);
            d.shift = smin;
            d.row   = '0;
            d.col   = '0;
        end else if (step_i) begin
            if (!last_col) begin
                d.col = q.col + 1'b1;
            end else begin
                d.col = '0;
                if (!last_row) begin
                    d.row = q.row + 1'b1;
                end else begin
                    d.row = '0;
                    if (q.shift == smax) begin
                        d.shift = smin;
                        d.cols  = q.cols + 1'b1;
                    end else begin
                        d.shift = q.shift + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ovl_score_cmp.sv
// Decides whether a finished placement beats the stored best, without division.
module ovl_score_cmp #(
    parameter int NW = 7
) (
    input  logic          best_valid_i,
    input  logic [NW-1:0] new_sum_i,
    input  logic [NW-1:0] new_cnt_i,
    input  logic [NW-1:0] best_sum_i,
    input  logic [NW-1:0] best_cnt_i,
    output logic          take_o
);
    logic [2*NW-1:0] lhs, rhs;

    always_comb begin
        lhs    = (2*NW)'(new_sum_i) * (2*NW)'(best_cnt_i);
        rhs    = (2*NW)'(best_sum_i) * (2*NW)'(new_cnt_i);
        take_o = !best_valid_i
              || (lhs < rhs)
              || ((lhs == rhs) && (new_cnt_i > best_cnt_i));
    end
endmodule

// File: rtl/ovl_search_top.sv
module ovl_search_top #(
    parameter int W = 8,
    parameter int H = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          mode_2d_i,
    output logic [$clog2(W)-1:0]          a_x_o,
    output logic [$clog2(H)-1:0]          a_y_o,
    input  logic                          a_pix_i,
    output logic [$clog2(W)-1:0]          b_x_o,
    output logic [$clog2(H)-1:0]          b_y_o,
    input  logic                          b_pix_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [$clog2(W+1)-1:0]        best_cols_o,
    output logic signed [$clog2(H):0]     best_shift_o,
    output logic [$clog2(W*H+1)-1:0]      best_count_o
);
    import ovl_pkg::*;

    localparam int CW = $clog2(W+1);
    localparam int SW = $clog2(H) + 1;
    localparam int NW = $clog2(W*H+1);

    typedef struct packed {
        ovl_state_t           st;
        logic                 mode;
        logic [NW-1:0]        acc;
        logic                 valid;
        logic [CW-1:0]        bcols;
        logic signed [SW-1:0] bshift;
        logic [NW-1:0]        bcnt;
        logic [NW-1:0]        bsum;
    } core_t;

    core_t q, d;

    logic                 w_init, w_step, w_mode;
    logic [CW-1:0]        w_cols;
    logic signed [SW-1:0] w_shift;
    logic [NW-1:0]        w_count;
    logic                 w_last_pix, w_last_off;
    logic [NW-1:0]        tot;
    logic                 take;

    assign w_mode = w_init ? mode_2d_i : q.mode;
    assign tot    = q.acc + NW'(a_pix_i ^ b_pix_i);

    ovl_offset_walker #(.W(W), .H(H)) walker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (w_init),
        .step_i     (w_step),
        .mode_2d_i  (w_mode),
        .a_x_o      (a_x_o),
        .a_y_o      (a_y_o),
        .b_x_o      (b_x_o),
        .b_y_o      (b_y_o),
        .cols_o     (w_cols),
        .shift_o    (w_shift),
        .count_o    (w_count),
        .last_pix_o (w_last_pix),
        .last_off_o (w_last_off)
    );

    ovl_score_cmp #(.NW(NW)) cmp_i (
        .best_valid_i (q.valid),
        .new_sum_i    (tot),
        .new_cnt_i    (w_count),
        .best_sum_i   (q.bsum),
        .best_cnt_i   (q.bcnt),
        .take_o       (take)
    );

    always_comb begin
        d      = q;
        w_init = 1'b0;
        w_step = 1'b0;
        case (q.st)
            ST_SCAN: begin
                w_step = 1'b1;
                if (w_last_pix) begin
                    d.acc = '0;
                    if (take) begin
                        d.valid  = 1'b1;
                        d.bcols  = w_cols;
                        d.bshift = w_shift;
                        d.bcnt   = w_count;
                        d.bsum   = tot;
                    end
                    if (w_last_off) begin
                        d.st = ST_DONE;
                    end
                end else begin
                    d.acc = tot;
                end
            end
            default: begin
                if (start_i) begin
                    w_init  = 1'b1;
                    d.st    = ST_SCAN;
                    d.mode  = mode_2d_i;
                    d.acc   = '0;
                    d.valid = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = (q.st == ST_SCAN);
    assign done_o       = (q.st == ST_DONE);
    assign best_cols_o  = q.bcols;
    assign best_shift_o = q.bshift;
    assign best_count_o = q.bcnt;
endmodule

// File: rtl/ovl_search_chk.sv
module ovl_search_chk #(
    parameter int W = 8,
    parameter int H = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      mode_2d_i,
    input logic [$clog2(W)-1:0]      a_x_o,
    input logic [$clog2(H)-1:0]      a_y_o,
    input logic [$clog2(W)-1:0]      b_x_o,
    input logic [$clog2(H)-1:0]      b_y_o,
    input logic                      busy_o,
    input logic                      done_o,
    input logic [$clog2(W+1)-1:0]    best_cols_o,
    input logic signed [$clog2(H):0] best_shift_o,
    input logic [$clog2(W*H+1)-1:0]  best_count_o
);
    localparam int SW = $clog2(H) + 1;

    logic          mode_seen;
    logic [SW-1:0] mag;

    assign mag = best_shift_o[SW-1] ? SW'(-best_shift_o) : SW'(best_shift_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_seen <= 1'b0;
        end else if (start_i && !busy_o) begin
            mode_seen <= mode_2d_i;
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(a_x_o) < W && int'(b_x_o) < W &&
                    int'(a_y_o) < H && int'(b_y_o) < H && a_x_o >= b_x_o));

    p_one_d_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_seen) |-> (best_shift_o == 0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(best_cols_o) &&
                                  $stable(best_shift_o) && $stable(best_count_o)));

    p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(best_count_o) == int'(best_cols_o) * (H - int'(mag))));
endmodule

bind ovl_search_top ovl_search_chk #(.W(W), .H(H)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_2d_i    (mode_2d_i),
    .a_x_o        (a_x_o),
    .a_y_o        (a_y_o),
    .b_x_o        (b_x_o),
    .b_y_o        (b_y_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .best_cols_o  (best_cols_o),
    .best_shift_o (best_shift_o),
    .best_count_o (best_count_o)
);

// File: tb/ovl_search_top_tb_top.sv
module ovl_search_top_tb_top;
    localparam int W  = 8;
    localparam int H  = 8;
    localparam int XW = $clog2(W);
    localparam int YW = $clog2(H);
    localparam int CW = $clog2(W+1);
    localparam int SW = $clog2(H) + 1;
    localparam int NW = $clog2(W*H+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [XW-1:0] a_x, b_x;
    logic [YW-1:0] a_y, b_y;
    logic a_pix, b_pix;
    logic busy, done;
    logic [CW-1:0] best_cols;
    logic signed [SW-1:0] best_shift;
    logic [NW-1:0] best_count;

    logic img_a [H][W];
    logic img_b [H][W];

    int total = 0;
    int bad = 0;
    int exp_c, exp_s, exp_n, exp_p;

    always #10 clk = ~clk;

    assign a_pix = img_a[a_y][a_x];
    assign b_pix = img_b[b_y][b_x];

    ovl_search_top #(.W(W), .H(H)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mode_2d_i    (mode),
        .a_x_o        (a_x),
        .a_y_o        (a_y),
        .a_pix_i      (a_pix),
        .b_x_o        (b_x),
        .b_y_o        (b_y),
        .b_pix_i      (b_pix),
        .busy_o       (busy),
        .done_o       (done),
        .best_cols_o  (best_cols),
        .best_shift_o (best_shift),
        .best_count_o (best_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference search from the requirements: exact fractions, sweep order c then s.
    task automatic model(input logic m2d);
        int bs, bn;
        bit have;
        have  = 0;
        bs    = 0;
        bn    = 1;
        exp_p = 0;
        for (int c = 1; c <= W; c++) begin
            for (int s = (m2d ? -(H-1) : 0); s <= (m2d ? H-1 : 0); s++) begin
                int sm, n;
                sm = 0;
                n  = 0;
                for (int y = 0; y < H; y++) begin
                    if (y - s >= 0 && y - s < H) begin
                        for (int x = W - c; x < W; x++) begin
                            sm += int'(img_a[y][x] ^ img_b[y-s][x-(W-c)]);
                            n++;
                        end
                    end
                end
                exp_p += n;
                if (!have || sm * bn < bs * n || (sm * bn == bs * n && n > bn)) begin
                    have  = 1;
                    bs    = sm;
                    bn    = n;
                    exp_c = c;
                    exp_s = s;
                    exp_n = n;
                end
            end
        end
    endtask

    task automatic fill_random();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                img_a[y][x] = 1'($urandom);
                img_b[y][x] = 1'($urandom);
            end
    endtask

    task automatic plant(input int c, input int s);
        for (int y = 0; y < H; y++)
            if (y - s >= 0 && y - s < H)
                for (int x = W - c; x < W; x++)
                    img_b[y-s][x-(W-c)] = img_a[y][x];
    endtask

    // Runs one search; optional second start pulse mid-run (must be ignored).
    task automatic run(input logic m2d, input string req, input bit poke);
        int cyc;
        int hc, hs, hn;
        model(m2d);
        @(negedge clk);
        mode  = m2d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", "busy after start", int'(busy), 1);
        check("R2", "done after start", int'(done), 0);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (busy) cyc++;
            if (poke && cyc == 10) begin
                start = 1'b1;
                mode  = ~m2d;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R3", "busy cycles", cyc, exp_p);
        check(req, "best cols", int'(best_cols), exp_c);
        check(req, "best shift", int'(best_shift), exp_s);
        check(req, "best count", int'(best_count), exp_n);
        hc = int'(best_cols);
        hs = int'(best_shift);
        hn = int'(best_count);
        repeat (3) @(negedge clk);
        check("R10", "done held", int'(done), 1);
        check("R10", "cols held", int'(best_cols), hc);
        check("R10", "shift held", int'(best_shift), hs);
        check("R10", "count held", int'(best_count), hn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                img_a[y][x] = 1'b0;
                img_b[y][x] = 1'b0;
            end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy at reset", int'(busy), 0);
        check("R1", "done at reset", int'(done), 0);
        check("R1", "cols at reset", int'(best_cols), 0);
        check("R1", "shift at reset", int'(best_shift), 0);
        check("R1", "count at reset", int'(best_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: blank images, all scores zero -> full overlap wins
        run(1'b1, "R6", 1'b0);
        check("R6", "blank cols directed", int'(best_cols), W);
        check("R6", "blank count directed", int'(best_count), W*H);

        // R6: complementary flat images, all scores one
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                img_a[y][x] = 1'b1;
                img_b[y][x] = 1'b0;
            end
        run(1'b1, "R6", 1'b0);
        check("R6", "flat cols directed", int'(best_cols), W);
        check("R6", "flat shift directed", int'(best_shift), 0);

        // R7: out-of-phase stripes, odd shifts match, +1 and -1 tie on count
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                img_a[y][x] = 1'(y % 2);
                img_b[y][x] = 1'((y + 1) % 2);
            end
        run(1'b1, "R7", 1'b0);
        check("R7", "stripe shift directed", int'(best_shift), -1);
        check("R7", "stripe count directed", int'(best_count), W*(H-1));

        // R4 R9: planted 2-D overlap in random images
        fill_random();
        plant(5, 2);
        run(1'b1, "R4", 1'b0);
        fill_random();
        plant(6, -3);
        run(1'b1, "R9", 1'b0);

        // R8: 1-D sweep, planted horizontal overlap
        fill_random();
        plant(3, 0);
        run(1'b0, "R8", 1'b0);
        check("R8", "1-D shift", int'(best_shift), 0);

        // R2: start during a run is ignored
        fill_random();
        run(1'b1, "R2", 1'b1);
        fill_random();
        run(1'b0, "R2", 1'b1);

        // R5: random images in both modes
        for (int k = 0; k < 4; k++) begin
            fill_random();
            run(1'(k % 2), "R5", 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule